// File: doc/BRIEF.md
# Six-Step Three-Phase Bridge Gate Sequencer

This block drives the six switch gates of a two-level three-phase bridge in square-wave (six-step) operation. The bridge has three legs. Leg A pairs upper switch S1 with lower switch S4. Leg B pairs S3 with S6. Leg C pairs S5 with S2. A clock divider sets the length of each step. Each step moves the bridge through the six active switch patterns in rotation. The `dir_i` input reverses the rotation and therefore the phase sequence.

On request, the sequencer parks in one of the two zero-voltage patterns. It picks whichever pattern needs the fewer leg changes. When the request is released, it resumes from the last active pattern. Every leg that changes at a step is held with both switches off for a programmable number of clock cycles before its new switch closes.

Alongside the gates, the block reports its current state number. It also reports the sign each line voltage (A-B, B-C, C-A) should have. Every output is registered. No input reaches an output in the same cycle.

Top module: `sixstep_gate_seq`

## Requirements
- R1: While reset is asserted, and afterwards until the first step, `gate_o` is 0, `state_o` is 0 and `vsign_o` is 0.
- R2: Within each leg (gate bits 0/3, 2/5, 4/1) the two gates are never both 1.
- R3: After a step, each leg whose switch pattern changes has both gates at 0 for exactly `dead_i` cycles, counted from the cycle after the stepping edge. Legs that keep their pattern are unaffected. Outside that window, in every nonzero state, each leg has exactly one gate at 1.
- R4: `gate_o` bit k-1 drives Sk. The settled on-sets are: state 1 = S1,S2,S6; state 2 = S1,S2,S3; state 3 = S2,S3,S4; state 4 = S3,S4,S5; state 5 = S4,S5,S6; state 6 = S5,S6,S1; state 7 = S1,S3,S5; state 8 = S2,S4,S6.
- R5: With `en_i` high, a step occurs on the edge where the divider count has reached `div_i`, giving a period of `div_i`+1 cycles. With `en_i` low, the state holds and the divider count clears to 0.
- R6: With `dir_i`=0, active states advance 1,2,...,6,1. With `dir_i`=1 they go 6,5,...,1,6. The first step out of state 0 goes to 1 (forward) or 6 (reverse).
- R7: A zero request is sampled only on a step edge. From an odd active state, or from state 0, the block goes to state 8. From an even active state it goes to state 7. While the request stays high, it remains in that zero state.
- R8: On the first step after the request drops, the block goes to the neighbour of the last active state visited, in the current direction.
- R9: `vsign_o` gives line A-B in bits [1:0], B-C in bits [3:2] and C-A in bits [5:4]. Each field is 01 for positive, 10 for negative and 00 for zero. The fields follow `state_o` in the same cycle, so states 0, 7 and 8 give all 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable for the step divider |
| dir_i | input | 1 | 0 = forward rotation, 1 = reverse |
| zero_req_i | input | 1 | Request to park in a zero-voltage state |
| div_i | input | DIV_W | Step period minus one, in clock cycles |
| dead_i | input | DEAD_W | Dead-time length in clock cycles |
| gate_o | output | 6 | Gate drives, bit k-1 = Sk |
| state_o | output | 4 | Current state number, 0 to 8 |
| vsign_o | output | 6 | Expected sign of the three line voltages |

## Verification
Suppose the state register or the last-active-position register holds a wrong value. `state_o` and `vsign_o` then differ from the reference at the very next step edge. `gate_o` differs once the dead-time window closes. A wrong leg-change mask or dead counter shows within the same step: a leg is off when it should be on, stays off too long, or switches with no gap. A wrong divider count shifts every later step edge, so it shows within one period. The bench compares all three outputs against a behavioural model on every cycle. A fault therefore surfaces no later than the first cycle on which it changes a port.

// File: rtl/sixstep_pkg.sv
package sixstep_pkg;

  localparam int unsigned ST_W = 4;

  // Upper-switch state of legs {C,B,A}; 1 = upper switch closed.
  function automatic logic [2:0] leg_pattern(input logic [ST_W-1:0] s);
    case (s)
      4'd1:    return 3'b001;
      4'd2:    return 3'b011;
      4'd3:    return 3'b010;
      4'd4:    return 3'b110;
      4'd5:    return 3'b100;
      4'd6:    return 3'b101;
      4'd7:    return 3'b111;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic is_active(input logic [ST_W-1:0] s);
    return (s >= 4'd1) && (s <= 4'd6);
  endfunction

  // Neighbour of an active position in the chosen rotation.
  function automatic logic [ST_W-1:0] neighbour(input logic [ST_W-1:0] p,
                                                input logic rev);
    if (!is_active(p))  return rev ? 4'd6 : 4'd1;
    if (!rev)           return (p == 4'd6) ? 4'd1 : ST_W'(p + 4'd1);
    return (p == 4'd1) ? 4'd6 : ST_W'(p - 4'd1);
  endfunction

  // Zero state reachable with fewest leg changes.
  function automatic logic [ST_W-1:0] zero_target(input logic [ST_W-1:0] s);
    if (s == 4'd0)   return 4'd8;
    if (is_active(s)) return s[0] ? 4'd8 : 4'd7;
    return s;
  endfunction

  function automatic logic [1:0] line_sign(input logic hi, input logic lo);
    if (hi && !lo) return 2'b01;
    if (!hi && lo) return 2'b10;
    return 2'b00;
  endfunction

endpackage

// File: rtl/sixstep_divider.sv
module sixstep_divider #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q >= div_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!en_i)    cnt_q <= '0;
    else if (tick_o)   cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end

  // R5: the count restarts after every step
  a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (cnt_q == '0));

  // R5: disabled divider is held clear
  a_r5_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (cnt_q == '0));

endmodule

// File: rtl/sixstep_stepper.sv
module sixstep_stepper
  import sixstep_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic            dir_i,
  input  logic            zero_req_i,
  output logic [ST_W-1:0] st_o,
  output logic [ST_W-1:0] st_nxt_o
);

  logic [ST_W-1:0] st_q;
  logic [ST_W-1:0] pos_q;

  always_comb begin
    if (zero_req_i) st_nxt_o = zero_target(st_q);
    else            st_nxt_o = neighbour(pos_q, dir_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      pos_q <= '0;
    end else if (tick_i) begin
      st_q <= st_nxt_o;
      if (is_active(st_nxt_o)) pos_q <= st_nxt_o;
    end
  end

  assign st_o = st_q;

  // R6: one active state follows another only as a rotation neighbour
  a_r6_neighbour: assert property (@(posedge clk) disable iff (!rst_n)
    (is_active(st_q) && is_active($past(st_q)) && (st_q != $past(st_q)))
      |-> ((st_q == neighbour($past(st_q), 1'b0)) ||
           (st_q == neighbour($past(st_q), 1'b1))));

  // R7: entry into a zero state matches parity of the state left
  a_r7_zero_choice: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == 4'd7 || st_q == 4'd8) && is_active($past(st_q)))
      |-> (st_q == ($past(st_q[0]) ? 4'd8 : 4'd7)));

  // R8: leaving a zero state resumes next to the remembered position
  a_r8_resume: assert property (@(posedge clk) disable iff (!rst_n)
    (is_active(st_q) && ($past(st_q) == 4'd7 || $past(st_q) == 4'd8))
      |-> (st_q == neighbour($past(pos_q), $past(dir_i))));

  // R5: the state moves only on a step edge
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(st_q));

endmodule

// File: rtl/sixstep_gate_shaper.sv
module sixstep_gate_shaper
  import sixstep_pkg::*;
#(
  parameter int unsigned DEAD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic [ST_W-1:0]   st_i,
  input  logic [ST_W-1:0]   st_nxt_i,
  input  logic [DEAD_W-1:0] dead_i,
  output logic [5:0]        gate_o
);

  localparam int unsigned LEGS = 3;

  function automatic int unsigned hi_bit(input int unsigned leg);
    return 2 * leg;            // S1, S3, S5
  endfunction

  function automatic int unsigned lo_bit(input int unsigned leg);
    return (2 * leg + 3) % 6;  // S4, S6, S2
  endfunction

  logic [LEGS-1:0]   chg_q;
  logic [DEAD_W-1:0] dcnt_q;
  logic [LEGS-1:0]   legs;
  logic [LEGS-1:0]   blank;
  logic              live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chg_q  <= '0;
      dcnt_q <= '0;
    end else if (step_i) begin
      dcnt_q <= dead_i;
      chg_q  <= (st_i == '0) ? '0 : (leg_pattern(st_i) ^ leg_pattern(st_nxt_i));
    end else if (dcnt_q != '0) begin
      dcnt_q <= dcnt_q - 1'b1;
    end
  end

  assign legs  = leg_pattern(st_i);
  assign live  = (st_i != '0);
  assign blank = (dcnt_q != '0) ? chg_q : '0;

  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    assign gate_o[hi_bit(g)] = live &  legs[g] & ~blank[g];
    assign gate_o[lo_bit(g)] = live & ~legs[g] & ~blank[g];

    // R2: the two switches of a leg are never closed together
    a_r2_leg_pair: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_o[hi_bit(g)] && gate_o[lo_bit(g)]));

    // R3: an open leg in a live state only inside the dead window
    a_r3_gap_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      (live && !gate_o[hi_bit(g)] && !gate_o[lo_bit(g)]) |-> (dcnt_q != '0));

    // R3: a leg that keeps its pattern is never blanked by a step
    a_r3_steady_leg: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && (st_i != '0) && (leg_pattern(st_i) == leg_pattern(st_nxt_i)))
        |=> (gate_o[hi_bit(g)] || gate_o[lo_bit(g)]));
  end

endmodule

// File: rtl/sixstep_gate_seq.sv
module sixstep_gate_seq
  import sixstep_pkg::*;
#(
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned DEAD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              dir_i,
  input  logic              zero_req_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [DEAD_W-1:0] dead_i,
  output logic [5:0]        gate_o,
  output logic [ST_W-1:0]   state_o,
  output logic [5:0]        vsign_o
);

  logic            tick;
  logic [ST_W-1:0] st;
  logic [ST_W-1:0] st_nxt;
  logic [2:0]      legs;

  sixstep_divider #(.DIV_W(DIV_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (en_i),
    .div_i  (div_i),
    .tick_o (tick)
  );

  sixstep_stepper u_step (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick),
    .dir_i      (dir_i),
    .zero_req_i (zero_req_i),
    .st_o       (st),
    .st_nxt_o   (st_nxt)
  );

  sixstep_gate_shaper #(.DEAD_W(DEAD_W)) u_shape (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_i   (tick),
    .st_i     (st),
    .st_nxt_i (st_nxt),
    .dead_i   (dead_i),
    .gate_o   (gate_o)
  );

  assign legs    = leg_pattern(st);
  assign state_o = st;
  assign vsign_o = {line_sign(legs[2], legs[0]),
                    line_sign(legs[1], legs[2]),
                    line_sign(legs[0], legs[1])};

  // R1: state 0 drives no gate at all
  a_r1_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == '0) |-> (gate_o == '0));

  // R9: zero-voltage and idle states report no line sign
  a_r9_zero_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == '0 || state_o == 4'd7 || state_o == 4'd8) |-> (vsign_o == '0));

  // R9: active states always show one positive and one negative line
  a_r9_pair: assert property (@(posedge clk) disable iff (!rst_n)
    is_active(state_o) |-> (($countones(vsign_o) == 2) &&
      ((vsign_o[0] + vsign_o[2] + vsign_o[4]) == 1)));

endmodule

// File: tb/sim_sixstep_gate_seq.sv
module sim_sixstep_gate_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       dir = 1'b0;
  logic       zreq = 1'b0;
  logic [15:0] div = 16'd3;
  logic [7:0]  dead = 8'd1;
  logic [5:0]  gate;
  logic [3:0]  state;
  logic [5:0]  vsign;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  string phase = "R1";

  always #2 clk = ~clk;

  sixstep_gate_seq u0 (
    .clk(clk), .rst_n(rst_n), .en_i(en), .dir_i(dir), .zero_req_i(zreq),
    .div_i(div), .dead_i(dead), .gate_o(gate), .state_o(state), .vsign_o(vsign)
  );

  // On-set masks written from the switch lists, bit k-1 = Sk.
  function automatic logic [5:0] onset(input int s);
    case (s)
      1: return 6'b100011;
      2: return 6'b000111;
      3: return 6'b001110;
      4: return 6'b011100;
      5: return 6'b111000;
      6: return 6'b110001;
      7: return 6'b010101;
      8: return 6'b101010;
      default: return 6'b000000;
    endcase
  endfunction

  function automatic logic [1:0] sgn(input logic x, input logic y);
    if (x == y) return 2'b00;
    return x ? 2'b01 : 2'b10;
  endfunction

  // Reference model state
  int m_cnt = 0, m_st = 0, m_pos = 0, m_dc = 0;
  logic [5:0] m_off = '0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_cnt = 0; m_st = 0; m_pos = 0; m_dc = 0; m_off = '0;
    end else if (!en) begin
      m_cnt = 0;
      if (m_dc > 0) m_dc--;
    end else if (m_cnt >= int'(div)) begin
      int nx;
      logic [5:0] o, n;
      m_cnt = 0;
      if (zreq) begin
        if (m_st == 0)                   nx = 8;
        else if (m_st >= 1 && m_st <= 6) nx = (m_st % 2 == 1) ? 8 : 7;
        else                             nx = m_st;
      end else if (m_pos == 0) nx = dir ? 6 : 1;
      else nx = dir ? ((m_pos + 4) % 6) + 1 : (m_pos % 6) + 1;
      o = onset(m_st); n = onset(nx);
      m_off = '0;
      if (m_st != 0) begin
        if (o[0] != n[0]) m_off |= 6'b001001;
        if (o[2] != n[2]) m_off |= 6'b100100;
        if (o[4] != n[4]) m_off |= 6'b010010;
      end
      m_dc = int'(dead);
      m_st = nx;
      if (nx >= 1 && nx <= 6) m_pos = nx;
    end else begin
      m_cnt++;
      if (m_dc > 0) m_dc--;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    logic [5:0] eg, es, m;
    m  = onset(m_st);
    eg = (m_dc > 0) ? (m & ~m_off) : m;
    es = (m_st == 0) ? 6'b0 : {sgn(m[4], m[0]), sgn(m[2], m[4]), sgn(m[0], m[2])};
    chk(state == 4'(m_st), phase, "state", state, m_st);
    chk(gate == eg, (m_dc > 0) ? "R3" : "R4", "gates", gate, eg);
    chk(vsign == es, "R9", "line signs", vsign, es);
    chk(!((gate[0] & gate[3]) | (gate[2] & gate[5]) | (gate[4] & gate[1])),
        "R2", "leg overlap", gate, 0);
  end

  always @(posedge clk) begin
    if (cyc >= 20000 && !done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=<20000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    phase = "R1";
    wait_cyc(5);
    chk(gate == 6'b0 && state == 4'd0 && vsign == 6'b0, "R1", "reset outputs",
        {state, gate}, 0);
    rst_n = 1'b1;
    wait_cyc(6);
    chk(gate == 6'b0 && state == 4'd0, "R1", "idle before enable", {state, gate}, 0);

    // Forward rotation, short dead time
    phase = "R6"; en = 1; div = 16'd3; dead = 8'd1; dir = 0;
    wait_cyc(60);
    // Longer dead time and period
    phase = "R3"; div = 16'd5; dead = 8'd3;
    wait_cyc(50);
    // Reverse rotation
    phase = "R6"; dir = 1; div = 16'd3; dead = 8'd1;
    wait_cyc(40);
    // Park in a zero state and hold
    phase = "R7"; zreq = 1;
    wait_cyc(22);
    phase = "R8"; zreq = 0;
    wait_cyc(20);
    // Enable gating and fast periods
    phase = "R5"; en = 0;
    wait_cyc(10);
    en = 1; div = 16'd0; dead = 8'd0;
    wait_cyc(20);
    div = 16'd2; dead = 8'd2;
    wait_cyc(30);
    // Zero request from the other parity, forward
    phase = "R7"; dir = 0; div = 16'd3; dead = 8'd1;
    wait_cyc(6);
    zreq = 1;
    wait_cyc(13);
    phase = "R8"; zreq = 0;
    wait_cyc(20);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule